// File: doc/BRIEF.md
# Aliased General Register File

This block stores the integer register state of a 64-bit processor core: 64 entries of 64 bits each. Two full-width read ports and one narrow 32-bit read port are combinational. A single write port stores either a full 64-bit value or a 32-bit value sign-extended to 64 bits. The highest index is a constant zero register: it reads as zero and absorbs writes.

Several architectural special registers have no storage of their own. They are views onto fixed entries of the same array. A global base, a procedure link and a vector base occupy entries 16, 18 and 20, and each is seen as the low word of its entry. The multiply-accumulate result occupies entry 17, with a high half and a low half that can be written independently. A condition flag is bit 0 of entry 19. Side ports read and partially update these views in the same cycle as ordinary register traffic. When a side update and a write-port write hit the same entry in one cycle, the write port wins.

Decode, execution, forwarding and exception handling sit outside this block.

Top module: `gpr_alias_file`

## Requirements
- R1: Read ports `ra` and `rb` return the full 64-bit entry at their index combinationally. A write takes effect at the rising clock edge, so a read of an index in the same cycle it is written returns the old value.
- R2: Index 63 always reads as zero on every read port. A write of any width to index 63 has no effect.
- R3: The narrow read port returns bits 31:0 of the entry at its index.
- R4: With `wr_narrow`=1 the write port stores `wr_data[31:0]` sign-extended to 64 bits. With `wr_narrow`=0 it stores `wr_data` unchanged.
- R5: The global base (entry 16), link (entry 18) and vector base (entry 20) side outputs show bits 31:0 of their entry. A side write stores its 32-bit value sign-extended into the whole entry.
- R6: Entry 17 holds the accumulate pair, with the high half in bits 63:32 and the low half in bits 31:0. A high write changes only bits 63:32, and a low write changes only bits 31:0. Both writes in one cycle update both halves.
- R7: The condition flag is bit 0 of entry 19. A flag write changes only that bit and keeps bits 63:1.
- R8: If the write port and a side write target the same entry in one cycle, the entry takes the write-port value in full.
- R9: A synchronous active-low reset clears every entry to zero.
- R10: A write-port write and a side write to different entries in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| ra_idx | input | 6 | Read port A index |
| ra_data | output | 64 | Read port A data |
| rb_idx | input | 6 | Read port B index |
| rb_data | output | 64 | Read port B data |
| na_idx | input | 6 | Narrow read index |
| na_data | output | 32 | Narrow read data, bits 31:0 of the entry |
| wr_en | input | 1 | Write port enable |
| wr_narrow | input | 1 | 1: sign-extend low 32 bits of wr_data |
| wr_idx | input | 6 | Write port index |
| wr_data | input | 64 | Write port data |
| gbase_we | input | 1 | Global base side write enable |
| gbase_wd | input | 32 | Global base side write value |
| gbase_q | output | 32 | Global base view |
| link_we | input | 1 | Link side write enable |
| link_wd | input | 32 | Link side write value |
| link_q | output | 32 | Link view |
| vbase_we | input | 1 | Vector base side write enable |
| vbase_wd | input | 32 | Vector base side write value |
| vbase_q | output | 32 | Vector base view |
| mhi_we | input | 1 | Accumulate high-half write enable |
| mhi_wd | input | 32 | Accumulate high-half value |
| mhi_q | output | 32 | Accumulate high half |
| mlo_we | input | 1 | Accumulate low-half write enable |
| mlo_wd | input | 32 | Accumulate low-half value |
| mlo_q | output | 32 | Accumulate low half |
| cflag_we | input | 1 | Condition flag write enable |
| cflag_wd | input | 1 | Condition flag value |
| cflag_q | output | 1 | Condition flag |

## Verification
The bench writes every entry with an arithmetic pattern and reads it back through both ports, in reverse order on port B. A design that let index 63 hold data, or that decoded indices wrongly, returns stale or foreign values. Narrow writes alternate the sign bit, so zero-extension or a missing extension shows up in the upper word. Partial updates are aimed at entries preloaded with distinct halves, so a design that clobbers the unwritten half of the accumulate pair or the upper flag bits is caught. Collisions between the write port and side writes expose a wrong priority or a lost merge. A read of an index in the cycle it is written catches a design that forwards the new value.

// File: rtl/gpr_alias_pkg.sv
// Package: fixed entry positions of the special-register views and the
// zero register. Assumes a 64-entry file; positions are architectural.
package gpr_alias_pkg;
    localparam int unsigned GA_ZERO_IDX   = 63;
    localparam int unsigned GA_GBASE_IDX  = 16;
    localparam int unsigned GA_MAC_IDX    = 17;
    localparam int unsigned GA_LINK_IDX   = 18;
    localparam int unsigned GA_CFLAG_IDX  = 19;
    localparam int unsigned GA_VBASE_IDX  = 20;
endpackage

// File: rtl/gpr_read_port.sv
// Combinational read mux. Returns the low OW bits of the addressed entry.
// Assumes the array already presents zero for the zero register.
module gpr_read_port #(
    parameter int NREG = 64,
    parameter int XLEN = 64,
    parameter int OW   = 64,
    localparam int IW  = $clog2(NREG)
) (
    input  logic [IW-1:0]   idx,
    input  logic [XLEN-1:0] regs [NREG],
    output logic [OW-1:0]   data
);
    logic [XLEN-1:0] sel;

    // Select the addressed entry.
    always_comb begin
        sel = regs[idx];
    end

    assign data = sel[OW-1:0];

    generate
        if (OW < XLEN) begin : g_trim
            logic unused_hi;
            assign unused_hi = ^sel[XLEN-1:OW];
        end
    endgenerate
endmodule

// File: rtl/gpr_alias_merge.sv
// Side-write merge: turns the special-register side writes into per-entry
// enables and full 64-bit next values. Partial views keep the bits they
// do not own by merging with the current entry contents.
// Assumes XLEN is even; the accumulate pair splits at XLEN/2.
module gpr_alias_merge
    import gpr_alias_pkg::*;
#(
    parameter int NREG = 64,
    parameter int XLEN = 64,
    localparam int HALF = XLEN / 2
) (
    input  logic [XLEN-1:0] mac_cur,
    input  logic [XLEN-1:0] flag_cur,
    input  logic            gbase_we,
    input  logic [HALF-1:0] gbase_wd,
    input  logic            link_we,
    input  logic [HALF-1:0] link_wd,
    input  logic            vbase_we,
    input  logic [HALF-1:0] vbase_wd,
    input  logic            mhi_we,
    input  logic [HALF-1:0] mhi_wd,
    input  logic            mlo_we,
    input  logic [HALF-1:0] mlo_wd,
    input  logic            cflag_we,
    input  logic            cflag_wd,
    output logic [NREG-1:0] side_we,
    output logic [XLEN-1:0] side_wd [NREG]
);
    logic [XLEN-1:0] gbase_ext, link_ext, vbase_ext, mac_nxt, flag_nxt;
    logic            unused_flag_lsb;

    // Sign-extend the word-wide views to the full entry width.
    always_comb begin
        gbase_ext = {{HALF{gbase_wd[HALF-1]}}, gbase_wd};
        link_ext  = {{HALF{link_wd[HALF-1]}},  link_wd};
        vbase_ext = {{HALF{vbase_wd[HALF-1]}}, vbase_wd};
    end

    // Merge half-word writes into the accumulate entry.
    always_comb begin
        mac_nxt[XLEN-1:HALF] = mhi_we ? mhi_wd : mac_cur[XLEN-1:HALF];
        mac_nxt[HALF-1:0]    = mlo_we ? mlo_wd : mac_cur[HALF-1:0];
    end

    // Replace only bit 0 of the flag entry.
    always_comb begin
        flag_nxt = {flag_cur[XLEN-1:1], cflag_wd};
    end

    assign unused_flag_lsb = flag_cur[0];

    generate
        for (genvar i = 0; i < NREG; i++) begin : g_ent
            if (i == GA_GBASE_IDX) begin : g_gb
                assign side_we[i] = gbase_we;
                assign side_wd[i] = gbase_ext;
            end else if (i == GA_LINK_IDX) begin : g_lk
                assign side_we[i] = link_we;
                assign side_wd[i] = link_ext;
            end else if (i == GA_VBASE_IDX) begin : g_vb
                assign side_we[i] = vbase_we;
                assign side_wd[i] = vbase_ext;
            end else if (i == GA_MAC_IDX) begin : g_mac
                assign side_we[i] = mhi_we | mlo_we;
                assign side_wd[i] = mac_nxt;
            end else if (i == GA_CFLAG_IDX) begin : g_fl
                assign side_we[i] = cflag_we;
                assign side_wd[i] = flag_nxt;
            end else begin : g_none
                assign side_we[i] = 1'b0;
                assign side_wd[i] = '0;
            end
        end
    endgenerate
endmodule

// File: rtl/gpr_entry_array.sv
// Storage array. One flop row per entry except the zero register, which is
// a constant. The write port has priority over a side write to the same
// entry. Synchronous active-low reset clears every row.
module gpr_entry_array
    import gpr_alias_pkg::*;
#(
    parameter int NREG = 64,
    parameter int XLEN = 64,
    localparam int IW  = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [IW-1:0]   wr_idx,
    input  logic [XLEN-1:0] wr_wd,
    input  logic [NREG-1:0] side_we,
    input  logic [XLEN-1:0] side_wd [NREG],
    output logic [XLEN-1:0] regs [NREG]
);
    generate
        for (genvar i = 0; i < NREG; i++) begin : g_row
            if (i == GA_ZERO_IDX) begin : g_zero
                logic unused_side;
                assign unused_side = side_we[i] ^ (^side_wd[i]);
                assign regs[i] = '0;
            end else begin : g_ff
                logic            hit;
                logic [XLEN-1:0] q;
                assign hit = wr_en && (wr_idx == IW'(i));

                // Update the row: reset, then write port, then side write.
                always_ff @(posedge clk) begin
                    if (!rst_n)          q <= '0;
                    else if (hit)        q <= wr_wd;
                    else if (side_we[i]) q <= side_wd[i];
                end

                assign regs[i] = q;
            end
        end
    endgenerate
endmodule

// File: rtl/gpr_alias_file.sv
// Top: general register file with special-register views on fixed entries.
// Reads are combinational; all writes land at the rising edge. Assumes
// NREG = 2**IW and the view positions in gpr_alias_pkg fall inside NREG.
module gpr_alias_file
    import gpr_alias_pkg::*;
#(
    parameter int NREG = 64,
    parameter int XLEN = 64,
    localparam int IW   = $clog2(NREG),
    localparam int HALF = XLEN / 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [IW-1:0]   ra_idx,
    output logic [XLEN-1:0] ra_data,
    input  logic [IW-1:0]   rb_idx,
    output logic [XLEN-1:0] rb_data,
    input  logic [IW-1:0]   na_idx,
    output logic [HALF-1:0] na_data,
    input  logic            wr_en,
    input  logic            wr_narrow,
    input  logic [IW-1:0]   wr_idx,
    input  logic [XLEN-1:0] wr_data,
    input  logic            gbase_we,
    input  logic [HALF-1:0] gbase_wd,
    output logic [HALF-1:0] gbase_q,
    input  logic            link_we,
    input  logic [HALF-1:0] link_wd,
    output logic [HALF-1:0] link_q,
    input  logic            vbase_we,
    input  logic [HALF-1:0] vbase_wd,
    output logic [HALF-1:0] vbase_q,
    input  logic            mhi_we,
    input  logic [HALF-1:0] mhi_wd,
    output logic [HALF-1:0] mhi_q,
    input  logic            mlo_we,
    input  logic [HALF-1:0] mlo_wd,
    output logic [HALF-1:0] mlo_q,
    input  logic            cflag_we,
    input  logic            cflag_wd,
    output logic            cflag_q
);
    logic [XLEN-1:0] regs    [NREG];
    logic [XLEN-1:0] side_wd [NREG];
    logic [NREG-1:0] side_we;
    logic [XLEN-1:0] wr_wd;

    // Shape the write-port value: full width or sign-extended low word.
    always_comb begin
        wr_wd = wr_narrow ? {{HALF{wr_data[HALF-1]}}, wr_data[HALF-1:0]}
                          : wr_data;
    end

    gpr_alias_merge #(.NREG(NREG), .XLEN(XLEN)) u_merge (
        .mac_cur  (regs[GA_MAC_IDX]),
        .flag_cur (regs[GA_CFLAG_IDX]),
        .gbase_we (gbase_we), .gbase_wd (gbase_wd),
        .link_we  (link_we),  .link_wd  (link_wd),
        .vbase_we (vbase_we), .vbase_wd (vbase_wd),
        .mhi_we   (mhi_we),   .mhi_wd   (mhi_wd),
        .mlo_we   (mlo_we),   .mlo_wd   (mlo_wd),
        .cflag_we (cflag_we), .cflag_wd (cflag_wd),
        .side_we  (side_we),
        .side_wd  (side_wd)
    );

    gpr_entry_array #(.NREG(NREG), .XLEN(XLEN)) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_wd   (wr_wd),
        .side_we (side_we),
        .side_wd (side_wd),
        .regs    (regs)
    );

    gpr_read_port #(.NREG(NREG), .XLEN(XLEN), .OW(XLEN)) u_rd_a (
        .idx (ra_idx), .regs (regs), .data (ra_data)
    );
    gpr_read_port #(.NREG(NREG), .XLEN(XLEN), .OW(XLEN)) u_rd_b (
        .idx (rb_idx), .regs (regs), .data (rb_data)
    );
    gpr_read_port #(.NREG(NREG), .XLEN(XLEN), .OW(HALF)) u_rd_n (
        .idx (na_idx), .regs (regs), .data (na_data)
    );

    // Present the special-register views from their fixed entries.
    always_comb begin
        gbase_q = regs[GA_GBASE_IDX][HALF-1:0];
        link_q  = regs[GA_LINK_IDX][HALF-1:0];
        vbase_q = regs[GA_VBASE_IDX][HALF-1:0];
        mhi_q   = regs[GA_MAC_IDX][XLEN-1:HALF];
        mlo_q   = regs[GA_MAC_IDX][HALF-1:0];
        cflag_q = regs[GA_CFLAG_IDX][0];
    end
endmodule

// File: rtl/gpr_alias_chk.sv
// Checker bound to the register file top. Observes the write controls and
// the storage rows and checks the update rules one cycle after each write.
module gpr_alias_chk
    import gpr_alias_pkg::*;
#(
    parameter int NREG = 64,
    parameter int XLEN = 64,
    localparam int IW   = $clog2(NREG),
    localparam int HALF = XLEN / 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic            wr_en,
    input logic            wr_narrow,
    input logic [IW-1:0]   wr_idx,
    input logic [XLEN-1:0] wr_data,
    input logic            mhi_we,
    input logic            mlo_we,
    input logic            cflag_we,
    input logic [IW-1:0]   ra_idx,
    input logic [XLEN-1:0] ra_data,
    input logic [XLEN-1:0] regs [NREG]
);
    logic full_mac, full_flag;
    assign full_mac  = wr_en && (wr_idx == IW'(GA_MAC_IDX));
    assign full_flag = wr_en && (wr_idx == IW'(GA_CFLAG_IDX));

    // R2
    zero_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ra_idx == IW'(GA_ZERO_IDX)) |-> (ra_data == '0));

    // R4
    narrow_sext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_narrow && wr_idx != IW'(GA_ZERO_IDX)) |=>
        (regs[$past(wr_idx)] ==
         {{HALF{$past(wr_data[HALF-1])}}, $past(wr_data[HALF-1:0])}));

    // R6
    mac_lo_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mhi_we && !mlo_we && !full_mac) |=>
        (regs[GA_MAC_IDX][HALF-1:0] == $past(regs[GA_MAC_IDX][HALF-1:0])));

    // R7
    flag_upper_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cflag_we && !full_flag) |=>
        (regs[GA_CFLAG_IDX][XLEN-1:1] == $past(regs[GA_CFLAG_IDX][XLEN-1:1])));

    // R8
    full_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full_mac && !wr_narrow && (mhi_we || mlo_we)) |=>
        (regs[GA_MAC_IDX] == $past(wr_data)));
endmodule

bind gpr_alias_file gpr_alias_chk #(.NREG(NREG), .XLEN(XLEN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_narrow (wr_narrow),
    .wr_idx    (wr_idx),
    .wr_data   (wr_data),
    .mhi_we    (mhi_we),
    .mlo_we    (mlo_we),
    .cflag_we  (cflag_we),
    .ra_idx    (ra_idx),
    .ra_data   (ra_data),
    .regs      (regs)
);

// File: tb/test_gpr_alias_file.sv
`timescale 1ns/1ps
module test_gpr_alias_file;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  ra_idx = '0, rb_idx = '0, na_idx = '0, wr_idx = '0;
    logic [63:0] ra_data, rb_data, wr_data = '0;
    logic [31:0] na_data;
    logic        wr_en = 1'b0, wr_narrow = 1'b0;
    logic        gbase_we = 1'b0, link_we = 1'b0, vbase_we = 1'b0;
    logic        mhi_we = 1'b0, mlo_we = 1'b0, cflag_we = 1'b0, cflag_wd = 1'b0;
    logic [31:0] gbase_wd = '0, link_wd = '0, vbase_wd = '0, mhi_wd = '0, mlo_wd = '0;
    logic [31:0] gbase_q, link_q, vbase_q, mhi_q, mlo_q;
    logic        cflag_q;
    int          n_vec = 0, n_bad = 0;

    always #4 clk = ~clk;

    gpr_alias_file i_gpr_alias_file (
        .clk(clk), .rst_n(rst_n),
        .ra_idx(ra_idx), .ra_data(ra_data), .rb_idx(rb_idx), .rb_data(rb_data),
        .na_idx(na_idx), .na_data(na_data),
        .wr_en(wr_en), .wr_narrow(wr_narrow), .wr_idx(wr_idx), .wr_data(wr_data),
        .gbase_we(gbase_we), .gbase_wd(gbase_wd), .gbase_q(gbase_q),
        .link_we(link_we), .link_wd(link_wd), .link_q(link_q),
        .vbase_we(vbase_we), .vbase_wd(vbase_wd), .vbase_q(vbase_q),
        .mhi_we(mhi_we), .mhi_wd(mhi_wd), .mhi_q(mhi_q),
        .mlo_we(mlo_we), .mlo_wd(mlo_wd), .mlo_q(mlo_q),
        .cflag_we(cflag_we), .cflag_wd(cflag_wd), .cflag_q(cflag_q)
    );

    function automatic logic [63:0] pat(input int i);
        return 64'h0123_4567_89AB_CDEF ^ (64'(i + 1) * 64'h9E37_79B9_7F4A_7C15);
    endfunction

    function automatic logic [31:0] npat(input int i);
        return ((i % 2) ? 32'hF000_0000 : 32'h0) ^ (32'(i) * 32'h0102_0305);
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        wr_en = 0; wr_narrow = 0; gbase_we = 0; link_we = 0; vbase_we = 0;
        mhi_we = 0; mlo_we = 0; cflag_we = 0;
    endtask

    // Inputs set after a negedge are committed at the next posedge.
    task automatic tick();
        @(negedge clk);
        idle();
        #1;
    endtask

    task automatic full_wr(input int idx, input logic [63:0] d, input logic nar);
        @(negedge clk);
        wr_en = 1; wr_idx = 6'(idx); wr_data = d; wr_narrow = nar;
        tick();
    endtask

    task automatic rd_a(input int idx);
        ra_idx = 6'(idx); #1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        // R9: all entries zero after reset
        for (int i = 0; i < 64; i++) begin
            rd_a(i); chk("R9 reset", ra_data, 64'h0);
        end

        // R1 R2: full-width sweep, read back on both ports
        for (int i = 0; i < 64; i++) full_wr(i, pat(i), 1'b0);
        for (int i = 0; i < 64; i++) begin
            ra_idx = 6'(i); rb_idx = 6'(63 - i); na_idx = 6'(i); #1;
            chk("R1 port a", ra_data, (i == 63) ? 64'h0 : pat(i));
            chk("R1 port b", rb_data, (i == 0) ? 64'h0 : pat(63 - i));
            chk("R3 narrow read", {32'h0, na_data}, (i == 63) ? 64'h0 : {32'h0, pat(i)[31:0]});
        end

        // R4: narrow writes with alternating sign, upper junk on wr_data
        for (int i = 0; i < 64; i++) full_wr(i, {32'hDEAD_BEEF, npat(i)}, 1'b1);
        for (int i = 0; i < 64; i++) begin
            rd_a(i);
            chk("R4 narrow write", ra_data,
                (i == 63) ? 64'h0 : {{32{npat(i)[31]}}, npat(i)});
        end

        // R2: write to zero register, both widths
        full_wr(63, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0);
        full_wr(63, 64'hFFFF_FFFF_8000_0001, 1'b1);
        rd_a(63); rb_idx = 63; na_idx = 63; #1;
        chk("R2 zero a", ra_data, 64'h0);
        chk("R2 zero b", rb_data, 64'h0);
        chk("R2 zero narrow", {32'h0, na_data}, 64'h0);

        // R1: same-cycle read returns old value, new value after edge
        full_wr(5, 64'h1111_1111_1111_1111, 1'b0);
        @(negedge clk);
        wr_en = 1; wr_idx = 5; wr_data = 64'h2222_3333_4444_5555; ra_idx = 5; #1;
        chk("R1 old value", ra_data, 64'h1111_1111_1111_1111);
        tick();
        chk("R1 new value", ra_data, 64'h2222_3333_4444_5555);

        // R5: word views sign-extended into whole entry
        @(negedge clk);
        gbase_we = 1; gbase_wd = 32'h8765_4321;
        link_we = 1;  link_wd  = 32'h1234_5678;
        vbase_we = 1; vbase_wd = 32'hC000_0004;
        tick();
        rd_a(16); chk("R5 gbase entry", ra_data, 64'hFFFF_FFFF_8765_4321);
        rd_a(18); chk("R5 link entry", ra_data, 64'h0000_0000_1234_5678);
        rd_a(20); chk("R5 vbase entry", ra_data, 64'hFFFF_FFFF_C000_0004);
        chk("R5 gbase view", {32'h0, gbase_q}, 64'h8765_4321);
        chk("R5 link view", {32'h0, link_q}, 64'h1234_5678);
        chk("R5 vbase view", {32'h0, vbase_q}, 64'hC000_0004);

        // R6: accumulate halves
        full_wr(17, 64'h1111_2222_3333_4444, 1'b0);
        @(negedge clk); mhi_we = 1; mhi_wd = 32'hAAAA_BBBB; tick();
        rd_a(17); chk("R6 high only", ra_data, 64'hAAAA_BBBB_3333_4444);
        @(negedge clk); mlo_we = 1; mlo_wd = 32'hCCCC_DDDD; tick();
        rd_a(17); chk("R6 low only", ra_data, 64'hAAAA_BBBB_CCCC_DDDD);
        @(negedge clk); mhi_we = 1; mhi_wd = 32'h0102_0304; mlo_we = 1; mlo_wd = 32'h0506_0708; tick();
        rd_a(17); chk("R6 both halves", ra_data, 64'h0102_0304_0506_0708);
        chk("R6 high view", {32'h0, mhi_q}, 64'h0102_0304);
        chk("R6 low view", {32'h0, mlo_q}, 64'h0506_0708);

        // R7: condition flag is bit 0 of entry 19
        full_wr(19, 64'hFFFF_0000_FFFF_FFFE, 1'b0);
        @(negedge clk); cflag_we = 1; cflag_wd = 1; tick();
        rd_a(19); chk("R7 flag set", ra_data, 64'hFFFF_0000_FFFF_FFFF);
        chk("R7 flag view", {63'h0, cflag_q}, 64'h1);
        @(negedge clk); cflag_we = 1; cflag_wd = 0; tick();
        rd_a(19); chk("R7 flag clear", ra_data, 64'hFFFF_0000_FFFF_FFFE);

        // R8: write port beats side write to same entry
        @(negedge clk);
        wr_en = 1; wr_idx = 17; wr_data = 64'h5A5A_5A5A_A5A5_A5A5;
        mhi_we = 1; mhi_wd = 32'h0; mlo_we = 1; mlo_wd = 32'h0; tick();
        rd_a(17); chk("R8 accumulate", ra_data, 64'h5A5A_5A5A_A5A5_A5A5);
        @(negedge clk);
        wr_en = 1; wr_narrow = 1; wr_idx = 19; wr_data = 64'h0000_0000_8000_0000;
        cflag_we = 1; cflag_wd = 1; tick();
        rd_a(19); chk("R8 flag", ra_data, 64'hFFFF_FFFF_8000_0000);
        @(negedge clk);
        wr_en = 1; wr_idx = 16; wr_data = 64'h7777_6666_5555_4444;
        gbase_we = 1; gbase_wd = 32'h1; tick();
        rd_a(16); chk("R8 gbase", ra_data, 64'h7777_6666_5555_4444);

        // R10: write port and side write to different entries
        @(negedge clk);
        wr_en = 1; wr_idx = 7; wr_data = 64'h0F0F_0F0F_0F0F_0F0F;
        link_we = 1; link_wd = 32'hFFFF_0000; tick();
        rd_a(7);  chk("R10 port entry", ra_data, 64'h0F0F_0F0F_0F0F_0F0F);
        rd_a(18); chk("R10 side entry", ra_data, 64'hFFFF_FFFF_FFFF_0000);

        // R9: reset clears populated entries
        @(negedge clk); rst_n = 0;
        @(negedge clk); rst_n = 1; #1;
        for (int i = 0; i < 64; i++) begin
            rd_a(i); chk("R9 re-reset", ra_data, 64'h0);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule